// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the serial front end of a two-wire EEPROM with an 11-bit byte address space. A fast system clock oversamples the SCL and SDA lines. Each line passes through a synchronizer and an optional digital glitch filter. The engine then finds START and STOP conditions and shifts bytes in and out, most significant bit first. It acknowledges by pulling SDA low through an open-drain enable.

After a START, the first byte is a control byte. Its upper nibble selects the device. Its next three bits become the top bits of the memory address. Its lowest bit chooses between reading and writing. In a write, the byte that follows sets the low eight address bits. Every later byte leaves on a one-cycle write strobe towards a page buffer, and the STOP that ends the transfer raises a commit pulse. In a read, bytes stream out of a synchronous memory port. The pointer advances each time the master acknowledges.

A busy input from the self-timed write logic suppresses every acknowledge while it is high. Any refused byte makes the engine stand aside until the next START.

Top module: `twiEepromSlave`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. After a STOP, no byte is acknowledged until a new START.
- R2: The control byte is taken MSB first. When its bits 7..4 equal 1010 and busyIn is low, the slave holds SDA low (sdaOe = 1) for the whole high phase of the ninth clock.
- R3: Control-byte bits 3..1 load pointer bits 10..8. In a write, the next byte loads pointer bits 7..0. Each following data byte gives a one-cycle wrEn with wrAddr equal to the pointer and wrData equal to the byte.
- R4: In a write, the word-address byte and every data byte are acknowledged.
- R5: After each data byte in a write, pointer bits 3..0 step by one and wrap from 15 to 0. Bits 10..4 stay fixed.
- R6: A STOP that ends a write which received at least one data byte gives a one-cycle wrCommit with SDA released.
- R7: A matching control byte with bit 0 = 1 is acknowledged. Bytes are then driven MSB first from the pointer. memRdEn is a one-cycle strobe with memRdAddr, and memRdData is valid the cycle after it.
- R8: When the master acknowledges a read byte, the pointer steps by one over the full 11 bits and wraps from 0x7FF to 0x000.
- R9: When the master leaves the ninth bit of a read byte high, the slave releases SDA and drives nothing until the next START.
- R10: A control byte whose bits 7..4 differ from 1010 is not acknowledged. No byte is acknowledged and no wrEn occurs until the next START.
- R11: With busyIn high at the end of any received byte, including a matching control byte, that byte is not acknowledged. The bus is then ignored until the next START.
- R12: A START in the middle of a byte abandons that byte, and the engine expects a control byte next.
- R13: sdaOe is low out of reset and during idle. In a legal transfer it changes only while SCL is low, a fixed number of clocks after the falling edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the pad |
| sdaIn | input | 1 | Serial data line as seen on the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busyIn | input | 1 | High while a self-timed write is in progress |
| memRdEn | output | 1 | One-cycle read request |
| memRdAddr | output | 11 | Read address |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |
| wrEn | output | 1 | One-cycle write strobe to the page buffer |
| wrAddr | output | 11 | Write address |
| wrData | output | 8 | Write data |
| wrCommit | output | 1 | One-cycle pulse: write transfer closed by STOP |

## Verification
The bench writes 18 bytes starting at offset 14 of a page. An engine that carried the page increment into bit 4 would write outside the page. It reads sequentially across address 0x7FF; a pointer that saturated or wrapped inside a page would return the wrong second byte. It sends a foreign control code, a matching code while busy, a data byte while busy, and an aborted half byte followed by a repeated START. A faulty engine would then acknowledge a byte it must refuse, strobe a write, or stay out of step. After a read ends without acknowledge, one more byte is clocked to show that the released line stays high. A monitor also watches that the data enable never moves while SCL is high.

// File: rtl/twiSlavePkg.sv
package twiSlavePkg;

  typedef enum logic [1:0] {
    KIND_CTRL,
    KIND_WADDR,
    KIND_WDATA
  } byteKind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_RXDEC,
    ST_ACKSET,
    ST_ACKHOLD,
    ST_TX,
    ST_TXACK,
    ST_TXFETCH,
    ST_TXWAIT,
    ST_IGNORE
  } ctlState_t;

  typedef struct packed {
    logic clrBit;
    logic cntBit;
    logic shiftIn;
    logic shiftTx;
    logic setOut;
    logic outLow;
    logic relNow;
    logic ldBlock;
    logic ldWord;
    logic incFull;
    logic incPage;
    logic rdReq;
    logic wrStrobe;
  } ctlStrobe_t;

endpackage

// File: rtl/twiBusSampler.sv
module twiBusSampler #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  logic [1:0] rawIn;
  logic [1:0] clean;
  logic       sclS;
  logic       sclP;
  logic       sdaP;

  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end

    if (FILTER_LEN == 0) begin : gNoFilt
      assign clean[g] = chain[SYNC_STAGES-1];
    end else begin : gFilt
      localparam int FLT_W = $clog2(FILTER_LEN + 1);
      logic [FLT_W-1:0] runCnt;
      logic             filt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runCnt <= '0;
          filt   <= 1'b1;
        end else if (chain[SYNC_STAGES-1] == filt) begin
          runCnt <= '0;
        end else if (runCnt == FLT_W'(FILTER_LEN - 1)) begin
          runCnt <= '0;
          filt   <= chain[SYNC_STAGES-1];
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
      assign clean[g] = filt;
    end
  end

  assign sclS = clean[1];
  assign sdaS = clean[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

endmodule

// File: rtl/twiSlaveDatapath.sv
module twiSlaveDatapath
  import twiSlavePkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 4,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              sdaS,
  input  logic [7:0]        memRdData,
  output logic [7:0]        rxByte,
  output logic              lastBit,
  output logic              txMsb,
  output logic              txNext,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              sdaOe
);

  localparam int BLK_W  = ADDR_W - 8;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [2:0]        bitCnt;
  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic [ADDR_W-1:0] ptr;
  logic              rdLoad;
  logic [HOLD_W-1:0] holdCnt;
  logic              pendLow;

  assign rxByte  = rxShift;
  assign lastBit = (bitCnt == 3'd7);
  assign txMsb   = txShift[7];
  assign txNext  = txShift[6];

  // bit counter and receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (stb.clrBit)                    bitCnt <= '0;
      else if (stb.cntBit | stb.shiftIn) bitCnt <= bitCnt + 1'b1;
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaS};
    end
  end

  // address pointer: block bits, word byte, page step or full step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.ldBlock) begin
      ptr[ADDR_W-1:8] <= rxShift[BLK_W:1];
    end else if (stb.ldWord) begin
      ptr[7:0] <= rxShift;
    end else if (stb.incFull) begin
      ptr <= ptr + 1'b1;
    end else if (stb.incPage) begin
      ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
    end
  end

  // memory side strobes and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRdEn   <= 1'b0;
      memRdAddr <= '0;
      rdLoad    <= 1'b0;
      txShift   <= '0;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
    end else begin
      memRdEn <= stb.rdReq;
      rdLoad  <= memRdEn;
      wrEn    <= stb.wrStrobe;
      if (stb.rdReq) memRdAddr <= ptr;
      if (stb.wrStrobe) begin
        wrAddr <= ptr;
        wrData <= rxShift;
      end
      if (rdLoad)           txShift <= memRdData;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  // open-drain output with hold delay after SCL falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOe   <= 1'b0;
      holdCnt <= '0;
      pendLow <= 1'b0;
    end else if (stb.relNow) begin
      sdaOe   <= 1'b0;
      holdCnt <= '0;
    end else if (stb.setOut) begin
      pendLow <= stb.outLow;
      holdCnt <= HOLD_W'(HOLD_CYC);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
      if (holdCnt == HOLD_W'(1)) sdaOe <= pendLow;
    end
  end

endmodule

// File: rtl/twiSlaveCtrl.sv
module twiSlaveCtrl
  import twiSlavePkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaS,
  input  logic       busyIn,
  input  logic [7:0] rxByte,
  input  logic       lastBit,
  input  logic       txMsb,
  input  logic       txNext,
  output ctlStrobe_t stb,
  output logic       wrCommit
);

  ctlState_t state, nxt;
  byteKind_t kind, kindN;
  logic      isRead, isReadN;
  logic      txLast, txLastN;
  logic      wrote, wroteN;
  logic      commitN;
  logic      accept;

  assign accept = ~busyIn & ((kind != KIND_CTRL) | (rxByte[7:4] == DEV_CODE));

  always_comb begin
    stb     = '0;
    nxt     = state;
    kindN   = kind;
    isReadN = isRead;
    txLastN = txLast;
    wroteN  = wrote;
    commitN = 1'b0;
    if (startEv) begin
      stb.clrBit = 1'b1;
      stb.relNow = 1'b1;
      nxt        = ST_RX;
      kindN      = KIND_CTRL;
      isReadN    = 1'b0;
      txLastN    = 1'b0;
    end else if (stopEv) begin
      stb.relNow = 1'b1;
      nxt        = ST_IDLE;
      commitN    = wrote;
      wroteN     = 1'b0;
      isReadN    = 1'b0;
    end else begin
      case (state)
        ST_RX: if (sclRise) begin
          stb.shiftIn = 1'b1;
          if (lastBit) nxt = ST_RXDEC;
        end
        ST_RXDEC: begin
          if (!accept) begin
            nxt = ST_IGNORE;
          end else begin
            nxt = ST_ACKSET;
            case (kind)
              KIND_CTRL: begin
                stb.ldBlock = 1'b1;
                if (rxByte[0]) isReadN = 1'b1;
                else           kindN   = KIND_WADDR;
              end
              KIND_WADDR: begin
                stb.ldWord = 1'b1;
                kindN      = KIND_WDATA;
              end
              default: begin
                stb.wrStrobe = 1'b1;
                stb.incPage  = 1'b1;
                wroteN       = 1'b1;
              end
            endcase
          end
        end
        ST_ACKSET: if (sclFall) begin
          stb.setOut = 1'b1;
          stb.outLow = 1'b1;
          nxt        = ST_ACKHOLD;
        end
        ST_ACKHOLD: begin
          if (sclRise && isRead) stb.rdReq = 1'b1;
          if (sclFall) begin
            stb.clrBit = 1'b1;
            stb.setOut = 1'b1;
            if (isRead) begin
              stb.outLow = ~txMsb;
              txLastN    = 1'b0;
              nxt        = ST_TX;
            end else begin
              nxt = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            stb.cntBit = 1'b1;
            if (lastBit) txLastN = 1'b1;
          end else if (sclFall) begin
            stb.setOut = 1'b1;
            if (txLast) begin
              stb.clrBit = 1'b1;
              txLastN    = 1'b0;
              nxt        = ST_TXACK;
            end else begin
              stb.shiftTx = 1'b1;
              stb.outLow  = ~txNext;
            end
          end
        end
        ST_TXACK: if (sclRise) begin
          if (!sdaS) begin
            stb.incFull = 1'b1;
            nxt         = ST_TXFETCH;
          end else begin
            nxt = ST_IGNORE;
          end
        end
        ST_TXFETCH: begin
          stb.rdReq = 1'b1;
          nxt       = ST_TXWAIT;
        end
        ST_TXWAIT: if (sclFall) begin
          stb.setOut = 1'b1;
          stb.outLow = ~txMsb;
          nxt        = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= KIND_CTRL;
      isRead   <= 1'b0;
      txLast   <= 1'b0;
      wrote    <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      state    <= nxt;
      kind     <= kindN;
      isRead   <= isReadN;
      txLast   <= txLastN;
      wrote    <= wroteN;
      wrCommit <= commitN;
    end
  end

endmodule

// File: rtl/twiEepromSlave.sv
module twiEepromSlave
  import twiSlavePkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILTER_LEN  = 3,
  parameter int         HOLD_CYC    = 4,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              busyIn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);

  logic       sdaS, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  logic       lastBit, txMsb, txNext;
  ctlStrobe_t stb;

  twiBusSampler #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILTER_LEN (FILTER_LEN)
  ) uSampler (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .sdaS   (sdaS),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startEv(startEv),
    .stopEv (stopEv)
  );

  twiSlaveCtrl #(
    .DEV_CODE(DEV_CODE)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startEv (startEv),
    .stopEv  (stopEv),
    .sdaS    (sdaS),
    .busyIn  (busyIn),
    .rxByte  (rxByte),
    .lastBit (lastBit),
    .txMsb   (txMsb),
    .txNext  (txNext),
    .stb     (stb),
    .wrCommit(wrCommit)
  );

  twiSlaveDatapath #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .HOLD_CYC(HOLD_CYC)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdaS     (sdaS),
    .memRdData(memRdData),
    .rxByte   (rxByte),
    .lastBit  (lastBit),
    .txMsb    (txMsb),
    .txNext   (txNext),
    .memRdEn  (memRdEn),
    .memRdAddr(memRdAddr),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .sdaOe    (sdaOe)
  );

endmodule

// File: rtl/twiEepromSlaveChk.sv
module twiEepromSlaveChk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic memRdEn,
  input logic wrEn,
  input logic wrCommit
);

  // R13: the data enable moves only while the clock line is low
  a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R3: a write strobe lasts a single cycle
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R3: write and read strobes never coincide
  a_r3_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && memRdEn));

  // R6: commit lasts a single cycle
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R6: commit comes with the line released
  a_r6_commit_released: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> !sdaOe);

  // R7: read request lasts a single cycle
  a_r7_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

endmodule

bind twiEepromSlave twiEepromSlaveChk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .memRdEn (memRdEn),
  .wrEn    (wrEn),
  .wrCommit(wrCommit)
);

// File: tb/tb_twiEepromSlave.sv
module tb_twiEepromSlave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 4;
  // {block[2:0], word[7:0], data[7:0], expected write address[10:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {3'd0, 8'h00, 8'h5A, 11'h000},
    {3'd3, 8'h7F, 8'hC3, 11'h37F},
    {3'd7, 8'hFE, 8'h01, 11'h7FE},
    {3'd4, 8'hA5, 8'hFF, 11'h4A5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        busyIn = 1'b0;
  logic        sdaOe;
  logic        memRdEn;
  logic [10:0] memRdAddr;
  logic [7:0]  memRdData;
  logic        wrEn;
  logic [10:0] wrAddr;
  logic [7:0]  wrData;
  logic        wrCommit;
  logic        sdaLine;

  logic [7:0]  mem [2048];
  logic [10:0] wrLog [64];
  int          wrCount = 0;
  int          commitCount = 0;
  int          holdViol = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  assign sdaLine = sdaM & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twiEepromSlave dut (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclM),
    .sdaIn    (sdaLine),
    .sdaOe    (sdaOe),
    .busyIn   (busyIn),
    .memRdEn  (memRdEn),
    .memRdAddr(memRdAddr),
    .memRdData(memRdData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrCommit (wrCommit)
  );

  // page buffer and array model
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr];
    if (wrEn) begin
      mem[wrAddr] <= wrData;
      wrLog[wrCount % 64] <= wrAddr;
      wrCount <= wrCount + 1;
    end
    if (wrCommit) commitCount <= commitCount + 1;
  end

  always @(sdaOe) if (rstN && sclM) holdViol++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    #(n * CLK_PERIOD);
  endtask

  task automatic startC();
    if (!sclM) begin
      sdaM = 1'b1; wq(Q);
      sclM = 1'b1; wq(Q);
    end
    sdaM = 1'b0; wq(Q);
    sclM = 1'b0; wq(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; wq(Q);
    sclM = 1'b1; wq(Q);
    sdaM = 1'b1; wq(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    wq(Q);
    sclM = 1'b1; wq(2 * Q);
    sclM = 1'b0; wq(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; wq(Q);
    sclM = 1'b1; wq(1);
    a0 = sdaLine; wq(2 * Q - 2);
    a1 = sdaLine; wq(1);
    sclM = 1'b0; wq(Q);
    acked = !a0 && !a1;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; wq(Q);
      sclM = 1'b1; wq(Q);
      b[i] = sdaLine; wq(Q);
      sclM = 1'b0; wq(Q);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; wq(Q);
    sclM = 1'b1; wq(2 * Q);
    sclM = 1'b0; wq(Q);
    sdaM = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wq(WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    bit          ack;
    logic [7:0]  rd;
    int          base;
    logic [10:0] expA;
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 7 + 3) & 255);
    wq(5);
    // R13: reset state
    check(sdaOe == 1'b0, "R13 reset sdaOe", int'(sdaOe), 0);
    check(wrEn == 1'b0 && memRdEn == 1'b0, "R13 reset strobes", int'({wrEn, memRdEn}), 0);
    check(wrCommit == 1'b0, "R13 reset commit", int'(wrCommit), 0);
    rstN = 1'b1;
    wq(10);

    // vector table: byte write then random read
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0]  blk;
      logic [7:0]  wa, dat;
      logic [10:0] ea;
      int          cc;
      {blk, wa, dat, ea} = VEC[v];
      cc = commitCount;
      startC();
      sendByte({4'b1010, blk, 1'b0}, ack);
      check(ack, "R2 control ack", int'(ack), 1);
      sendByte(wa, ack);
      check(ack, "R4 word address ack", int'(ack), 1);
      sendByte(dat, ack);
      check(ack, "R4 data ack", int'(ack), 1);
      check(wrAddr == ea, "R3 write address", int'(wrAddr), int'(ea));
      check(wrData == dat, "R3 write data", int'(wrData), int'(dat));
      stopC();
      check(commitCount == cc + 1, "R6 commit on stop", commitCount, cc + 1);
      wq(20);
      startC();
      sendByte({4'b1010, blk, 1'b0}, ack);
      sendByte(wa, ack);
      startC();
      sendByte({4'b1010, blk, 1'b1}, ack);
      check(ack, "R7 read control ack", int'(ack), 1);
      recvByte(1'b0, rd);
      check(rd == dat, "R7 read data", int'(rd), int'(dat));
      check(sdaOe == 1'b0, "R9 release after nack", int'(sdaOe), 0);
      stopC();
      wq(20);
    end

    // R5: page write rolls inside the 16-byte page
    base = wrCount;
    startC();
    sendByte(8'b1010_101_0, ack);
    sendByte(8'h3E, ack);
    for (int k = 0; k < 18; k++) begin
      sendByte(8'(8'h80 + k), ack);
      if (!ack) check(1'b0, "R4 page data ack", 0, 1);
    end
    stopC();
    check(wrCount == base + 18, "R5 page byte count", wrCount, base + 18);
    for (int k = 0; k < 18; k += 2) begin
      expA = {3'd5, 4'h3, 4'((4'hE + k) & 15)};
      check(wrLog[(base + k) % 64] == expA, "R5 page wrap address",
            int'(wrLog[(base + k) % 64]), int'(expA));
    end
    wq(20);

    // R8: sequential read wraps across the top of the space
    startC();
    sendByte(8'b1010_111_0, ack);
    sendByte(8'hFF, ack);
    startC();
    sendByte(8'b1010_111_1, ack);
    recvByte(1'b1, rd);
    check(rd == mem[11'h7FF], "R8 read at top", int'(rd), int'(mem[11'h7FF]));
    recvByte(1'b0, rd);
    check(rd == mem[11'h000], "R8 read after wrap", int'(rd), int'(mem[11'h000]));
    recvByte(1'b0, rd);
    check(rd == 8'hFF, "R9 no drive after nack", int'(rd), 255);
    stopC();
    wq(20);

    // R10: foreign control code
    base = wrCount;
    startC();
    sendByte(8'hB0, ack);
    check(!ack, "R10 foreign code nack", int'(ack), 0);
    sendByte(8'h12, ack);
    check(!ack, "R10 ignored byte nack", int'(ack), 0);
    sendByte(8'h34, ack);
    check(wrCount == base, "R10 no write", wrCount - base, 0);
    stopC();
    wq(20);

    // R11: busy refuses a matching control byte and a data byte
    busyIn = 1'b1;
    startC();
    sendByte(8'hA0, ack);
    check(!ack, "R11 busy control nack", int'(ack), 0);
    stopC();
    busyIn = 1'b0;
    wq(20);
    base = commitCount;
    startC();
    sendByte(8'hA2, ack);
    sendByte(8'h40, ack);
    busyIn = 1'b1;
    sendByte(8'h99, ack);
    check(!ack, "R11 busy data nack", int'(ack), 0);
    busyIn = 1'b0;
    sendByte(8'h98, ack);
    check(!ack, "R11 ignored till start", int'(ack), 0);
    stopC();
    check(commitCount == base, "R11 no commit", commitCount - base, 0);
    wq(20);

    // R12: START in the middle of a byte
    startC();
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    startC();
    sendByte(8'b1010_010_0, ack);
    check(ack, "R12 control after abort", int'(ack), 1);
    sendByte(8'h10, ack);
    sendByte(8'h77, ack);
    check(wrAddr == 11'h210 && wrData == 8'h77, "R12 write after abort",
          int'({wrAddr, wrData}), int'({11'h210, 8'h77}));
    stopC();
    wq(20);

    // R1: no response after STOP without a new START
    sclM = 1'b0; wq(Q);
    sendByte(8'hA0, ack);
    check(!ack, "R1 no ack after stop", int'(ack), 0);
    sclM = 1'b1; wq(Q);
    stopC();
    wq(20);

    check(holdViol == 0, "R13 sdaOe moved with SCL high", holdViol, 0);
    check(sdaOe == 1'b0, "R13 idle released", int'(sdaOe), 0);
    finish();
  end

endmodule